// File: doc/BRIEF.md
# Radix-4 Computed Partial Product Multiplier

This block multiplies two unsigned operands, `a` of `A_W` bits and `b` of `B_W` bits, and returns the exact `A_W+B_W` bit product. The `b` operand is cut into two-bit digits. For each digit, a four-way selector picks one of four multiples of `a`: zero, `a`, twice `a` or three times `a`. No lookup table is used for this.

Twice `a` is a wired one-bit left shift. Three times `a` comes from one adder that adds `a` to twice `a`. That single adder serves every digit slice. Each selected multiple is moved left by two bits per digit position. The weighted partial products are then summed in a balanced binary adder tree. Working with two-bit digits halves the number of partial products compared with a one-bit-per-row array, and it removes one level from the tree.

A parameter sets the latency. The block can be purely combinational, or it can place one register stage between the partial-product stage and the adder tree. The output-valid flag tracks whichever latency is chosen. The block is meant to sit inline in a datapath that presents an operand pair together with a valid strobe.

Top module: `r4m_mult`

## Requirements
- R1: When `out_valid` is high, `product` equals the exact unsigned product of the operand pair whose `in_valid` produced it, over all input values. The product is `A_W+B_W` bits wide.
- R2: Digit k of `b` is bits 2k+1..2k. It selects 0, 1, 2 or 3 times `a` for code values 0, 1, 2 and 3 respectively, weighted by 2^(2k). A `b` of 1 therefore returns `a` unchanged.
- R3: When `B_W` is odd, the most significant digit of `b` is zero-extended by one bit, and products stay exact.
- R4: With `PIPE`=1, `out_valid` and `product` appear exactly one clock after the rising edge that sampled `in_valid`, `a` and `b`.
- R5: With `PIPE`=0, the block is combinational: `out_valid` equals `in_valid` and `product` follows `a` and `b` in the same cycle, with no clock edge.
- R6: With `PIPE`=1, `out_valid` is low while `rst_n` is low, and it stays low until an input is accepted after reset.
- R7: With `PIPE`=1, a cycle with `in_valid` low gives a cycle with `out_valid` low one clock later. Back-to-back valid inputs each give a result on consecutive cycles.
- R8: All-ones operands give (2^A_W-1)(2^B_W-1) with no loss of bits.
- R9: A zero in either operand gives a zero product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional register stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand pair on `a` and `b` is valid |
| a | input | A_W | Multiplicand, unsigned |
| b | input | B_W | Multiplier, unsigned, split into two-bit digits |
| out_valid | output | 1 | `product` holds a valid result |
| product | output | A_W+B_W | Unsigned product |

## Verification
On every cycle, the bound checker keeps its own copy of the operands at the configured latency. It then tests the output-valid timing, the exact product, the zero-operand and all-ones boundaries, and the unit-multiplier case. Some behaviours only the bench scenarios can show. These are exhaustive coverage of an odd-width combinational instance, where the zero-extended top digit takes every code. They also include the valid pattern across reset, bubbles and back-to-back streams, and a long run of random wide operands compared against a plain behavioural multiply.

// File: rtl/r4m_pkg.sv
package r4m_pkg;

    // Code carried by one two-bit digit of the multiplier operand
    typedef enum logic [1:0] {
        MUL_ZERO  = 2'd0,
        MUL_ONE   = 2'd1,
        MUL_TWO   = 2'd2,
        MUL_THREE = 2'd3
    } mul_sel_e;

    // Number of two-bit digits needed to cover a width (odd widths round up)
    function automatic int digit_count(input int width);
        return (width + 1) / 2;
    endfunction

endpackage

// File: rtl/r4m_multiples.sv
// Shared multiple generator: one adder produces 3x for every slice
module r4m_multiples #(
    parameter int A_W = 8,
    localparam int M_W = A_W + 2
) (
    input  logic [A_W-1:0] a,
    output logic [M_W-1:0] a_x1,
    output logic [M_W-1:0] a_x2,
    output logic [M_W-1:0] a_x3
);

    always_comb begin
        a_x1 = M_W'(a);
        a_x2 = M_W'({a, 1'b0});
        a_x3 = a_x1 + a_x2;
    end

endmodule

// File: rtl/r4m_digit_slice.sv
// One digit slice: picks a multiple of a and moves it to its weight
module r4m_digit_slice
    import r4m_pkg::*;
#(
    parameter int A_W   = 8,
    parameter int EXT_W = 16,
    parameter int SHIFT = 0,
    localparam int M_W  = A_W + 2
) (
    input  logic [1:0]       digit,
    input  logic [M_W-1:0]   a_x1,
    input  logic [M_W-1:0]   a_x2,
    input  logic [M_W-1:0]   a_x3,
    output logic [EXT_W-1:0] pp
);

    logic [M_W-1:0] picked;

    always_comb begin
        unique case (mul_sel_e'(digit))
            MUL_ZERO:  picked = '0;
            MUL_ONE:   picked = a_x1;
            MUL_TWO:   picked = a_x2;
            MUL_THREE: picked = a_x3;
            default:   picked = '0;
        endcase
        pp = EXT_W'(picked) << SHIFT;
    end

endmodule

// File: rtl/r4m_sum_tree.sv
// Balanced binary adder tree; unused leaves are tied to zero
module r4m_sum_tree #(
    parameter int W    = 16,
    parameter int N_IN = 4
) (
    input  logic [N_IN-1:0][W-1:0] terms,
    output logic [W-1:0]           sum
);

    localparam int LVLS   = (N_IN > 1) ? $clog2(N_IN) : 0;
    localparam int LEAVES = 1 << LVLS;

    for (genvar l = 0; l <= LVLS; l++) begin : g_lvl
        localparam int CNT = LEAVES >> l;
        logic [W-1:0] s [CNT];
        if (l == 0) begin : g_leaf
            for (genvar j = 0; j < CNT; j++) begin : g_in
                if (j < N_IN) begin : g_real
                    assign s[j] = terms[j];
                end else begin : g_pad
                    assign s[j] = '0;
                end
            end
        end else begin : g_node
            for (genvar j = 0; j < CNT; j++) begin : g_add
                assign s[j] = g_lvl[l-1].s[2*j] + g_lvl[l-1].s[2*j+1];
            end
        end
    end

    assign sum = g_lvl[LVLS].s[0];

endmodule

// File: rtl/r4m_mult.sv
module r4m_mult
    import r4m_pkg::*;
#(
    parameter int A_W  = 8,
    parameter int B_W  = 8,
    parameter bit PIPE = 1'b1,
    localparam int P_W = A_W + B_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic [A_W-1:0] a,
    input  logic [B_W-1:0] b,
    output logic           out_valid,
    output logic [P_W-1:0] product
);

    localparam int ND    = digit_count(B_W);
    localparam int BX_W  = 2 * ND;
    localparam int EXT_W = A_W + BX_W;
    localparam int M_W   = A_W + 2;

    typedef struct packed {
        logic                      vld;
        logic [ND-1:0][EXT_W-1:0]  pp;
    } stage_t;

    logic [BX_W-1:0]          b_ext;
    logic [M_W-1:0]           a_x1, a_x2, a_x3;
    logic [ND-1:0][EXT_W-1:0] pp_now;
    logic [EXT_W-1:0]         sum_full;
    stage_t                   st_d, st_q;

    assign b_ext = BX_W'(b);

    r4m_multiples #(.A_W(A_W)) u_mults (
        .a    (a),
        .a_x1 (a_x1),
        .a_x2 (a_x2),
        .a_x3 (a_x3)
    );

    for (genvar k = 0; k < ND; k++) begin : g_dig
        r4m_digit_slice #(
            .A_W   (A_W),
            .EXT_W (EXT_W),
            .SHIFT (2 * k)
        ) u_slice (
            .digit (b_ext[2*k +: 2]),
            .a_x1  (a_x1),
            .a_x2  (a_x2),
            .a_x3  (a_x3),
            .pp    (pp_now[k])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        st_d.pp  = pp_now;
    end

    if (PIPE) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_q <= '0;
            end else begin
                st_q <= st_d;
            end
        end
    end else begin : g_comb
        assign st_q = st_d;
    end

    r4m_sum_tree #(.W(EXT_W), .N_IN(ND)) u_tree (
        .terms (st_q.pp),
        .sum   (sum_full)
    );

    assign out_valid = st_q.vld;
    assign product   = P_W'(sum_full);

endmodule

// File: rtl/r4m_mult_chk.sv
module r4m_mult_chk #(
    parameter int A_W  = 8,
    parameter int B_W  = 8,
    parameter bit PIPE = 1'b1,
    localparam int P_W = A_W + B_W
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_valid,
    input logic [A_W-1:0] a,
    input logic [B_W-1:0] b,
    input logic           out_valid,
    input logic [P_W-1:0] product
);

    logic           v_d1;
    logic [A_W-1:0] a_d1;
    logic [B_W-1:0] b_d1;
    logic           exp_v;
    logic [A_W-1:0] exp_a;
    logic [B_W-1:0] exp_b;
    logic [P_W-1:0] exp_p;
    logic [P_W-1:0] max_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_d1 <= 1'b0;
            a_d1 <= '0;
            b_d1 <= '0;
        end else begin
            v_d1 <= in_valid;
            a_d1 <= a;
            b_d1 <= b;
        end
    end

    always_comb begin
        exp_v = PIPE ? v_d1 : in_valid;
        exp_a = PIPE ? a_d1 : a;
        exp_b = PIPE ? b_d1 : b;
        exp_p = P_W'(exp_a) * P_W'(exp_b);
        max_p = P_W'(1) - (P_W'(1) << A_W) - (P_W'(1) << B_W);
    end

    // R4 R5 R6 R7
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == exp_v);

    // R1
    product_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> product == exp_p);

    // R9
    zero_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (exp_a == '0 || exp_b == '0)) |-> product == '0);

    // R8
    max_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (&exp_a) && (&exp_b)) |-> product == max_p);

    // R2
    unit_digit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && exp_b == B_W'(1)) |-> product == P_W'(exp_a));

endmodule

bind r4m_mult r4m_mult_chk #(.A_W(A_W), .B_W(B_W), .PIPE(PIPE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .a         (a),
    .b         (b),
    .out_valid (out_valid),
    .product   (product)
);

// File: tb/test_r4m_mult.sv
`timescale 1ns/1ps
module test_r4m_mult;

    localparam int BA_W = 16;
    localparam int BB_W = 12;
    localparam int BP_W = BA_W + BB_W;
    localparam int SA_W = 4;
    localparam int SB_W = 3;
    localparam int SP_W = SA_W + SB_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    // pipelined wide instance
    logic            bv = 1'b0;
    logic [BA_W-1:0] ba = '0;
    logic [BB_W-1:0] bb = '0;
    logic            bov;
    logic [BP_W-1:0] bprod;

    r4m_mult #(.A_W(BA_W), .B_W(BB_W), .PIPE(1'b1)) i_r4m_mult (
        .clk(clk), .rst_n(rst_n), .in_valid(bv), .a(ba), .b(bb),
        .out_valid(bov), .product(bprod)
    );

    // combinational odd-width instance
    logic            sv = 1'b0;
    logic [SA_W-1:0] sa = '0;
    logic [SB_W-1:0] sb = '0;
    logic            sov;
    logic [SP_W-1:0] sprod;

    r4m_mult #(.A_W(SA_W), .B_W(SB_W), .PIPE(1'b0)) i_r4m_mult_small (
        .clk(clk), .rst_n(rst_n), .in_valid(sv), .a(sa), .b(sb),
        .out_valid(sov), .product(sprod)
    );

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // behavioural reference for the pipelined instance
    bit     ev = 1'b0;
    longint ep = 0;
    longint q_p[$];
    bit     q_v[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            ev <= 1'b0;
        end else begin
            q_v.push_back(bv);
            q_p.push_back(longint'(ba) * longint'(bb));
            ev <= q_v.pop_front();
            ep <= q_p.pop_front();
        end
    end

    // every-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (bov !== ev) begin
                failures++;
                $display("FAIL R4/R6/R7 out_valid actual=%0b expected=%0b t=%0t", bov, ev, $time);
            end
            if (ev) begin
                checks++;
                if (longint'(bprod) != ep) begin
                    failures++;
                    $display("FAIL R1 product actual=%0d expected=%0d t=%0t", bprod, ep, $time);
                end
            end
        end
    end

    task automatic drive_big(input bit v, input longint x, input longint y);
        @(negedge clk);
        bv = v;
        ba = BA_W'(x);
        bb = BB_W'(y);
    endtask

    task automatic check_small(input bit v, input int x, input int y);
        sv = v;
        sa = SA_W'(x);
        sb = SB_W'(y);
        #1;
        checks++;
        if (sov !== v || int'(sprod) != x * y) begin
            failures++;
            $display("FAIL R3/R5 small a=%0d b=%0d actual=%0d/%0b expected=%0d/%0b",
                     x, y, sprod, sov, x * y, v);
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL R4 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R6: reset holds out_valid low even with valid inputs
        bv = 1'b1; ba = 16'h1234; bb = 12'h056;
        repeat (3) @(negedge clk);
        checks++;
        if (bov !== 1'b0) begin
            failures++;
            $display("FAIL R6 out_valid in reset actual=%0b expected=0", bov);
        end
        bv = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        // R9 zero operands, R8 all ones, R2 unit multiplier
        drive_big(1, 0, 12'hABC);
        drive_big(1, 16'hBEEF, 0);
        drive_big(1, 16'hFFFF, 12'hFFF);
        drive_big(1, 16'h9A5C, 1);
        // R2 each digit code alone, at every digit position
        for (int k = 0; k < BB_W / 2; k++) begin
            for (int c = 1; c < 4; c++) drive_big(1, 16'hD3A7, longint'(c) << (2 * k));
        end
        // R7 bubbles interleaved and back-to-back
        drive_big(0, 16'h1111, 12'h222);
        drive_big(1, 16'h0003, 12'h005);
        drive_big(0, 16'hFFFF, 12'hFFF);
        drive_big(0, 16'h0001, 12'h001);
        drive_big(1, 16'h8000, 12'h800);
        drive_big(1, 16'h7FFF, 12'h7FF);
        // R1 random stream with random gaps
        for (int i = 0; i < 3000; i++) begin
            drive_big(($urandom % 4) != 0, longint'($urandom), longint'($urandom));
        end
        drive_big(0, 0, 0);

        // R3 R5 exhaustive on odd-width combinational instance
        for (int x = 0; x < (1 << SA_W); x++) begin
            for (int y = 0; y < (1 << SB_W); y++) begin
                check_small((x + y) % 3 != 0, x, y);
            end
        end

        drive_big(0, 0, 0);
        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule